// File: doc/BRIEF.md
# Recursive Doubling Prefix-Sum Sequencer

The block takes N values in parallel and returns N running totals in parallel: output lane k holds the sum of input lanes 0 through k. It uses N identical lanes, each with an accumulator, a routing register and an enable bit. A small controller steps them through log2(N) rounds.

In round i, every lane copies its accumulator into its routing register. The routing registers then move up by 2^i lanes, and every lane does this whether or not it is enabled. Lanes whose index is below 2^i are then switched off, and the lanes still on add the routed value to their accumulators. After the last round, all lanes are switched back on and the accumulators are captured into an output register. A one-cycle done pulse marks that capture.

The data width and lane count are parameters, and N must be a power of two. Addition is two's-complement and wraps. A start request that arrives while a computation is in flight is ignored.

Top module: `psum_seq`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `sum_data` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures `in_data` and makes `busy` high from the next cycle on.
- R3: On completion, lane k of `sum_data` (bits k*W+W-1 down to k*W) equals the sum of input lanes 0..k as given at the accepted start.
- R4: `done` is high for exactly one cycle. It rises 4*log2(N)+1 clock edges after the edge that accepted `start`, and it rises in the same cycle that `busy` falls.
- R5: A `start` sampled while `busy` is high is ignored. The running computation keeps its original inputs and its timing.
- R6: All sums are taken modulo 2^W, so a sum that overflows wraps around.
- R7: `sum_data` changes only in the cycle in which `done` rises. It holds its value while the block is idle, even when `in_data` changes.
- R8: `done` and `busy` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a computation; honoured only when idle |
| in_data | input | N*W | Input values, lane k at bits k*W+W-1 down to k*W |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when results are captured |
| sum_data | output | N*W | Prefix sums, lane k at bits k*W+W-1 down to k*W |

## Verification
The assertions check the handshake on every cycle. They cover the single-cycle done pulse, done never overlapping busy, busy starting after an accepted start, busy ending only with done, and the output holding still except at completion. Only the bench scenarios can show the values themselves. These are the prefix totals for several data patterns, including negative numbers and wrap-around, the exact latency count, and that a start arriving mid-run leaves the result and its timing unchanged.

// File: rtl/psum_pkg.sv
// Package psum_pkg
// Shared phase encoding for the prefix-sum sequencer.
// Assumes nothing beyond the controller stepping phases in order.
package psum_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COPY,
        PH_SHIFT,
        PH_MASK,
        PH_ADD,
        PH_STORE
    } phase_t;
endpackage

// File: rtl/psum_ctrl.sv
// Module psum_ctrl
// Sequences the prefix-sum rounds: one pass of copy, shift, mask and add
// for each round, then a store phase. The round counter runs from 0 up to
// LOG-1. Assumes LOG >= 1.
module psum_ctrl
    import psum_pkg::*;
#(
    parameter int LOG = 3,
    parameter int SW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output phase_t        phase,
    output logic [SW-1:0] step,
    output logic          load,
    output logic          busy
);
    localparam logic [SW-1:0] LAST = SW'(LOG - 1);

    // Phase and round register: walks the fixed schedule once per accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_COPY;
                        step  <= '0;
                    end
                end
                PH_COPY:  phase <= PH_SHIFT;
                PH_SHIFT: phase <= PH_MASK;
                PH_MASK:  phase <= PH_ADD;
                PH_ADD: begin
                    if (step == LAST) begin
                        phase <= PH_STORE;
                    end else begin
                        step  <= step + 1'b1;
                        phase <= PH_COPY;
                    end
                end
                PH_STORE: phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Load strobe and busy flag derived from the phase
    assign load = start && (phase == PH_IDLE);
    assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/psum_route.sv
// Module psum_route
// Combinational shift network for the routing registers. Lane k receives
// lane k - 2^step. Lanes below 2^step receive zero, because values that
// leave the array are dropped, not wrapped. Assumes N is a power of two.
module psum_route #(
    parameter int N   = 8,
    parameter int W   = 16,
    parameter int LOG = 3,
    parameter int SW  = 2
) (
    input  logic [N-1:0][W-1:0] rr_q,
    input  logic [SW-1:0]       step,
    output logic [N-1:0][W-1:0] rr_shift
);
    localparam int DEPTH = 1 << SW;

    for (genvar k = 0; k < N; k++) begin : g_lane
        logic [DEPTH-1:0][W-1:0] cand;
        // Candidate source for each possible distance; out-of-array gives zero
        for (genvar s = 0; s < DEPTH; s++) begin : g_dist
            if (s < LOG && k >= (1 << s)) begin : g_src
                assign cand[s] = rr_q[k - (1 << s)];
            end else begin : g_edge
                assign cand[s] = '0;
            end
        end
        // Select the distance of the current round
        assign rr_shift[k] = cand[step];
    end
endmodule

// File: rtl/psum_lane.sv
// Module psum_lane
// One processing lane: accumulator, routing register and enable bit.
// The copy and shift phases act whatever the enable. The mask phase turns
// the lane off when its index is below 2^step. The add phase only updates
// enabled lanes.
module psum_lane
    import psum_pkg::*;
#(
    parameter int W   = 16,
    parameter int IDX = 0,
    parameter int SW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        phase,
    input  logic [SW-1:0] step,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic [W-1:0]  shift_in,
    output logic [W-1:0]  acc,
    output logic [W-1:0]  rr
);
    logic en_q;

    // Lane state update according to the current phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            rr   <= '0;
            en_q <= 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (load) begin
                        acc  <= load_val;
                        en_q <= 1'b1;
                    end
                end
                PH_COPY:  rr   <= acc;
                PH_SHIFT: rr   <= shift_in;
                PH_MASK:  en_q <= ((IDX >> step) != 0);
                PH_ADD: begin
                    if (en_q) acc <= acc + rr;
                end
                PH_STORE: en_q <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/psum_seq.sv
// Module psum_seq (top)
// Parallel prefix sum by recursive doubling over N lanes in log2(N) rounds
// of four cycles each, followed by a store cycle that registers the
// results and pulses done. Assumes N is a power of two and N >= 2.
module psum_seq
    import psum_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*W-1:0] in_data,
    output logic           busy,
    output logic           done,
    output logic [N*W-1:0] sum_data
);
    localparam int LOG = $clog2(N);
    localparam int SW  = (LOG > 1) ? $clog2(LOG) : 1;

    phase_t               phase;
    logic [SW-1:0]        step;
    logic                 load;
    logic [N-1:0][W-1:0]  acc;
    logic [N-1:0][W-1:0]  rr;
    logic [N-1:0][W-1:0]  rr_shift;
    logic [N*W-1:0]       sum_q;
    logic                 done_q;

    psum_ctrl #(.LOG(LOG), .SW(SW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase),
        .step  (step),
        .load  (load),
        .busy  (busy)
    );

    psum_route #(.N(N), .W(W), .LOG(LOG), .SW(SW)) u_route (
        .rr_q     (rr),
        .step     (step),
        .rr_shift (rr_shift)
    );

    for (genvar k = 0; k < N; k++) begin : g_lanes
        psum_lane #(.W(W), .IDX(k), .SW(SW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase    (phase),
            .step     (step),
            .load     (load),
            .load_val (in_data[k*W +: W]),
            .shift_in (rr_shift[k]),
            .acc      (acc[k]),
            .rr       (rr[k])
        );
    end

    // Output capture and completion pulse at the store phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (phase == PH_STORE);
            if (phase == PH_STORE) sum_q <= acc;
        end
    end

    assign done     = done_q;
    assign sum_data = sum_q;
endmodule

// File: rtl/psum_seq_chk.sv
// Module psum_seq_chk
// Handshake and output-hold properties of psum_seq, checked every cycle.
// Bound to every psum_seq instance.
module psum_seq_chk #(
    parameter int N = 8,
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [N*W-1:0] sum_data
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(sum_data)); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
endmodule

bind psum_seq psum_seq_chk #(.N(N), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sum_data (sum_data)
);

// File: tb/psum_seq_bench.sv
// Directed bench for psum_seq: one task per scenario, each checking its results.
module psum_seq_bench;
    localparam int N   = 8;
    localparam int W   = 16;
    localparam int LOG = $clog2(N);
    localparam int LAT = 4 * LOG + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           busy;
    logic           done;
    logic [N*W-1:0] sum_data;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] vals [N];

    always #4 clk = ~clk;

    psum_seq #(.N(N), .W(W)) u_psum_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_data  (in_data),
        .busy     (busy),
        .done     (done),
        .sum_data (sum_data)
    );

    task automatic chk(input bit ok, input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] expect_sums();
        logic [W-1:0] run = '0;
        logic [N*W-1:0] r = '0;
        for (int k = 0; k < N; k++) begin
            run = run + vals[k];
            r[k*W +: W] = run;
        end
        return r;
    endfunction

    // Runs one computation from vals; optionally pulses start mid-run with other data
    task automatic run_job(input bit intrude, input string tag);
        logic [N*W-1:0] exp;
        int cyc;
        exp = expect_sums();
        @(negedge clk);
        for (int k = 0; k < N; k++) in_data[k*W +: W] = vals[k];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, {"R2 busy after start ", tag}, N*W'(busy), N*W'(1));
        cyc = 0;
        while (done !== 1'b1 && cyc < 100) begin
            if (intrude && cyc == 5) begin
                in_data = ~in_data;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == LAT, {"R4 latency ", tag}, N*W'(cyc), N*W'(LAT));
        chk(busy === 1'b0, {"R8 busy low at done ", tag}, N*W'(busy), '0);
        chk(sum_data === exp, {intrude ? "R5 result kept " : "R3 prefix sums ", tag}, sum_data, exp);
        @(negedge clk);
        chk(done === 1'b0, {"R4 done one cycle ", tag}, N*W'(done), '0);
    endtask

    task automatic t_reset();
        chk(busy === 1'b0, "R1 busy at reset", N*W'(busy), '0);
        chk(done === 1'b0, "R1 done at reset", N*W'(done), '0);
        chk(sum_data === '0, "R1 sums at reset", sum_data, '0);
    endtask

    task automatic t_example();
        int ex [N] = '{0, 2, 4, 6, 8, 7, 5, 3};
        for (int k = 0; k < N; k++) vals[k] = W'(ex[k]);
        run_job(1'b0, "example");
        chk(sum_data[(N-1)*W +: W] === W'(35), "R3 total 35", N*W'(sum_data[(N-1)*W +: W]), N*W'(35));
    endtask

    task automatic t_signed();
        for (int k = 0; k < N; k++) vals[k] = W'(k * 3 - 11);
        run_job(1'b0, "signed");
    endtask

    task automatic t_wrap();
        for (int k = 0; k < N; k++) vals[k] = 16'hC001 + W'(k);
        run_job(1'b0, "R6 wrap");
        chk(sum_data[W +: W] === 16'h8003, "R6 lane1 wraps", N*W'(sum_data[W +: W]), N*W'(16'h8003));
    endtask

    task automatic t_intrude();
        for (int k = 0; k < N; k++) vals[k] = W'(100 + 7 * k);
        run_job(1'b1, "intrude");
    endtask

    task automatic t_hold();
        logic [N*W-1:0] held;
        held = sum_data;
        in_data = {N{16'h5A5A}};
        repeat (6) @(negedge clk);
        chk(sum_data === held, "R7 output held", sum_data, held);
        chk(done === 1'b0 && busy === 1'b0, "R7 stays idle", N*W'({done, busy}), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_example();
        t_signed();
        t_wrap();
        t_intrude();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule